// File: doc/BRIEF.md
# Prioritized Interrupt Selector with Delegation

This block decides which local interrupt a hart should take next. Each cycle it combines the pending and enable vectors, the per-bit delegation mask, the current privilege level and the global machine and supervisor enable bits. It registers a valid flag and the index of the winning interrupt, so a trap-entry stage downstream sees values that hold steady for a whole cycle.

When the hart runs a guest (virtualization input high), interrupts that belong to the host take precedence. They are gated by a separate host supervisor enable, and when one of them wins the block raises a force-to-host flag. If none of them wins, the guest-supervisor software, timer and external bits move down one position and compete in the normal way. Outside guest mode those three guest bits never take part. The lowest bit index always has the highest priority.

Top module: `irq_select`

## Requirements
- R1: A synchronous reset, sampled on the rising clock edge, clears `irqValid`, `irqIndex` and `forceHost` to zero.
- R2: A bit is a candidate only when it is set in both `pending` and `enable`. A bit that is pending but not enabled, or enabled but not pending, is never selected.
- R3: Privilege encoding: 0 = user, 1 = supervisor, 3 = machine. A candidate whose `delegMask` bit is 0 qualifies when the privilege is below machine, or when it is machine and `machineIe` is 1.
- R4: A candidate whose `delegMask` bit is 1 qualifies when the privilege is user, or when it is supervisor and `superIe` is 1. At machine privilege it never qualifies.
- R5: When several bits qualify, `irqIndex` reports the lowest qualifying bit index and `irqValid` is 1.
- R6: When no bit qualifies, `irqValid` is 0 and `irqIndex` is 0.
- R7: With `virtOn` at 0, bits 2, 6 and 10 (the guest-supervisor software, timer and external bits) are removed from the candidate set and `forceHost` is 0.
- R8: With `virtOn` at 1, candidates other than bits 2, 6 and 10 qualify when the privilege is user, or when it is supervisor and `hostIe` is 1. The delegation mask is ignored on this path. If any of them qualifies, the lowest one wins and `forceHost` is 1.
- R9: With `virtOn` at 1 and no candidate qualifying under R8, only candidate bits 2, 6 and 10 remain. They are moved to positions 1, 5 and 9 and then qualified by R3 and R4 using the delegation bit at the new position. `forceHost` is 0.
- R10: The outputs change only on a rising clock edge and reflect the inputs sampled at that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| pending | input | 32 | Pending interrupt bits |
| enable | input | 32 | Per-bit interrupt enables |
| delegMask | input | 32 | 1 = bit handled at supervisor level |
| privLevel | input | 2 | Current privilege (0 user, 1 supervisor, 3 machine) |
| machineIe | input | 1 | Global machine interrupt enable |
| superIe | input | 1 | Global supervisor interrupt enable |
| hostIe | input | 1 | Host supervisor interrupt enable used in guest mode |
| virtOn | input | 1 | Hart is running a guest |
| irqValid | output | 1 | A qualifying interrupt was found |
| irqIndex | output | 5 | Index of the winning interrupt |
| forceHost | output | 1 | The winner came from the host path in guest mode |

## Verification
The bench targets the privilege corners of delegation. At machine privilege a delegated bit must stay blocked even with every enable set. At user privilege both global enables must be ignored. A design that mixed up the two enables, or the comparison against the current level, would take or drop those interrupts.

Priority is tested with bits at both ends of the vector and with a delegated low bit that is blocked while a higher non-delegated bit wins. An encoder scanning from the wrong end would report the high bit.

In guest mode the bench checks three things: host bits beat guest bits, delegation is ignored on the host path, and a moved guest bit uses the delegation bit at its new position. A missing or wrong-direction shift would report indices 2, 6 or 10, or fail to find anything.

// File: rtl/irq_select_pkg.sv
package irq_select_pkg;

  typedef enum logic [1:0] {
    PRIV_USER  = 2'd0,
    PRIV_SUPER = 2'd1,
    PRIV_RSVD  = 2'd2,
    PRIV_MACH  = 2'd3
  } privT;

  // Strobes passed from the gate control to the selection datapath.
  typedef struct packed {
    logic machineOk;  // non-delegated bits may be taken
    logic superOk;    // delegated bits may be taken
    logic hostOk;     // host bits may be taken while a guest runs
    logic virtOn;     // guest mode selects the host-first path
  } gateT;

endpackage

// File: rtl/irq_select_gate.sv
module irq_select_gate
  import irq_select_pkg::*;
(
  input  logic [1:0] privLevel,
  input  logic       machineIe,
  input  logic       superIe,
  input  logic       hostIe,
  input  logic       virtOn,
  output gateT       gate
);

  privT priv;

  always_comb begin
    priv = privT'(privLevel);
    // Machine-level bits open below machine or with the global machine enable.
    gate.machineOk = (priv != PRIV_MACH) || machineIe;
    // Supervisor-level bits open in user mode or in supervisor with its enable.
    gate.superOk   = (priv == PRIV_USER) || ((priv == PRIV_SUPER) && superIe);
    // Host bits in guest mode use the host copy of the supervisor enable.
    gate.hostOk    = (priv == PRIV_USER) || ((priv == PRIV_SUPER) && hostIe);
    gate.virtOn    = virtOn;
  end

endmodule

// File: rtl/irq_select_prio.sv
module irq_select_prio #(
  parameter int unsigned WIDTH = 32,
  localparam int unsigned IDX_W = (WIDTH > 1) ? $clog2(WIDTH) : 1
) (
  input  logic [WIDTH-1:0] vec,
  output logic             hit,
  output logic [IDX_W-1:0] idx
);

  // Scan from the top down so the lowest set bit is written last.
  always_comb begin
    hit = |vec;
    idx = '0;
    for (int i = WIDTH - 1; i >= 0; i--) begin
      if (vec[i]) idx = IDX_W'(i);
    end
  end

endmodule

// File: rtl/irq_select_path.sv
module irq_select_path
  import irq_select_pkg::*;
#(
  parameter int unsigned WIDTH = 32,
  parameter logic [WIDTH-1:0] GUEST_MASK = WIDTH'(12'h444),
  localparam int unsigned IDX_W = (WIDTH > 1) ? $clog2(WIDTH) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] pending,
  input  logic [WIDTH-1:0] enable,
  input  logic [WIDTH-1:0] delegMask,
  input  gateT             gate,
  output logic             irqValid,
  output logic [IDX_W-1:0] irqIndex,
  output logic             forceHost
);

  logic [WIDTH-1:0] candidates;
  logic [WIDTH-1:0] hostBits;
  logic [WIDTH-1:0] guestShifted;
  logic [WIDTH-1:0] hostHits;
  logic [WIDTH-1:0] baseSet;
  logic [WIDTH-1:0] qualified;
  logic [WIDTH-1:0] finalSet;
  logic             useHost;
  logic             selHit;
  logic [IDX_W-1:0] selIdx;

  always_comb begin
    candidates   = pending & enable;
    hostBits     = candidates & ~GUEST_MASK;
    guestShifted = (candidates & GUEST_MASK) >> 1;
    hostHits     = hostBits & {WIDTH{gate.hostOk}};
    useHost      = gate.virtOn && (|hostHits);
    baseSet      = gate.virtOn ? guestShifted : hostBits;
    qualified    = (baseSet & ~delegMask & {WIDTH{gate.machineOk}})
                 | (baseSet &  delegMask & {WIDTH{gate.superOk}});
    finalSet     = useHost ? hostHits : qualified;
  end

  irq_select_prio #(.WIDTH(WIDTH)) u_prio (
    .vec (finalSet),
    .hit (selHit),
    .idx (selIdx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      irqValid  <= 1'b0;
      irqIndex  <= '0;
      forceHost <= 1'b0;
    end else begin
      irqValid  <= selHit;
      irqIndex  <= selIdx;
      forceHost <= useHost;
    end
  end

  // R1: reset leaves no interrupt and no force flag
  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (!irqValid && !forceHost && irqIndex == '0));

  // R8: the force flag only accompanies a real selection
  a_r8_force_has_valid: assert property (@(posedge clk) disable iff (rst)
    forceHost |-> irqValid);

  // R7: outside guest mode no guest bit is reported and no force is raised
  a_r7_no_guest_index: assert property (@(posedge clk) disable iff (rst)
    !gate.virtOn |=> (!forceHost && !(irqValid && GUEST_MASK[irqIndex])));

  // R3: with every gate closed nothing can be selected
  a_r3_all_gates_closed: assert property (@(posedge clk) disable iff (rst)
    (!gate.machineOk && !gate.superOk && !gate.hostOk) |=> !irqValid);

  // R6: an empty pending vector yields no selection
  a_r6_empty_none: assert property (@(posedge clk) disable iff (rst)
    (pending == '0) |=> (!irqValid && irqIndex == '0));

endmodule

// File: rtl/irq_select.sv
module irq_select
  import irq_select_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic [31:0] pending,
  input  logic [31:0] enable,
  input  logic [31:0] delegMask,
  input  logic [1:0]  privLevel,
  input  logic        machineIe,
  input  logic        superIe,
  input  logic        hostIe,
  input  logic        virtOn,
  output logic        irqValid,
  output logic [4:0]  irqIndex,
  output logic        forceHost
);

  gateT gate;

  irq_select_gate u_gate (
    .privLevel (privLevel),
    .machineIe (machineIe),
    .superIe   (superIe),
    .hostIe    (hostIe),
    .virtOn    (virtOn),
    .gate      (gate)
  );

  irq_select_path #(.WIDTH(32)) u_path (
    .clk       (clk),
    .rst       (rst),
    .pending   (pending),
    .enable    (enable),
    .delegMask (delegMask),
    .gate      (gate),
    .irqValid  (irqValid),
    .irqIndex  (irqIndex),
    .forceHost (forceHost)
  );

endmodule

// File: tb/irq_select_tb.sv
module irq_select_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] pending = '0;
  logic [31:0] enable = '0;
  logic [31:0] delegMask = '0;
  logic [1:0]  privLevel = 2'd3;
  logic        machineIe = 1'b0;
  logic        superIe = 1'b0;
  logic        hostIe = 1'b0;
  logic        virtOn = 1'b0;
  logic        irqValid;
  logic [4:0]  irqIndex;
  logic        forceHost;

  int checks = 0;
  int errors = 0;

  localparam logic [1:0] U = 2'd0, S = 2'd1, M = 2'd3;

  always #4 clk = ~clk;

  irq_select u_dut (
    .clk(clk), .rst(rst), .pending(pending), .enable(enable),
    .delegMask(delegMask), .privLevel(privLevel), .machineIe(machineIe),
    .superIe(superIe), .hostIe(hostIe), .virtOn(virtOn),
    .irqValid(irqValid), .irqIndex(irqIndex), .forceHost(forceHost)
  );

  task automatic expectOut(input logic v, input logic [4:0] idx, input logic f,
                           input string tag);
    checks++;
    if (irqValid !== v || irqIndex !== idx || forceHost !== f) begin
      errors++;
      $display("FAIL %s: got valid=%0b idx=%0d force=%0b, expected valid=%0b idx=%0d force=%0b",
               tag, irqValid, irqIndex, forceHost, v, idx, f);
    end
  endtask

  // Drive at the falling edge, let one rising edge pass, sample 1 ns later.
  task automatic apply(input logic [31:0] p, input logic [31:0] e, input logic [31:0] d,
                       input logic [1:0] pr, input logic mie, input logic sie,
                       input logic hie, input logic vo);
    @(negedge clk);
    pending = p; enable = e; delegMask = d; privLevel = pr;
    machineIe = mie; superIe = sie; hostIe = hie; virtOn = vo;
    @(posedge clk);
    #1;
  endtask

  task automatic testReset();
    @(negedge clk);
    rst = 1'b1;
    apply(32'hFFFF_FFFF, 32'hFFFF_FFFF, '0, U, 1, 1, 1, 0);
    expectOut(0, 0, 0, "R1 reset with everything pending");
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic testCandidates();
    apply(32'h0000_0008, 32'h0000_0010, '0, M, 1, 1, 0, 0);
    expectOut(0, 0, 0, "R2 pending and enable disjoint");
    apply(32'h0000_0018, 32'h0000_0010, '0, M, 1, 1, 0, 0);
    expectOut(1, 4, 0, "R2 only the enabled pending bit");
  endtask

  task automatic testPriority();
    apply(32'h0000_0880, 32'hFFFF_FFFF, '0, M, 1, 0, 0, 0);
    expectOut(1, 7, 0, "R5 bits 7 and 11");
    apply(32'h8000_0001, 32'hFFFF_FFFF, '0, M, 1, 0, 0, 0);
    expectOut(1, 0, 0, "R5 bits 0 and 31");
    apply(32'h8000_0000, 32'hFFFF_FFFF, '0, M, 1, 0, 0, 0);
    expectOut(1, 31, 0, "R5 top bit alone");
  endtask

  task automatic testMachineGate();
    apply(32'h80, 32'h80, '0, M, 0, 1, 1, 0);
    expectOut(0, 0, 0, "R3 machine with enable off");
    apply(32'h80, 32'h80, '0, S, 0, 0, 0, 0);
    expectOut(1, 7, 0, "R3 supervisor ignores machine enable");
    apply(32'h80, 32'h80, '0, U, 0, 0, 0, 0);
    expectOut(1, 7, 0, "R3 user ignores machine enable");
  endtask

  task automatic testDelegation();
    apply(32'h20, 32'h20, 32'h20, M, 1, 1, 1, 0);
    expectOut(0, 0, 0, "R4 delegated bit at machine");
    apply(32'h20, 32'h20, 32'h20, S, 1, 0, 1, 0);
    expectOut(0, 0, 0, "R4 supervisor with enable off");
    apply(32'h20, 32'h20, 32'h20, S, 0, 1, 0, 0);
    expectOut(1, 5, 0, "R4 supervisor with enable on");
    apply(32'h20, 32'h20, 32'h20, U, 0, 0, 0, 0);
    expectOut(1, 5, 0, "R4 user ignores supervisor enable");
    apply(32'h82, 32'h82, 32'h02, M, 1, 1, 0, 0);
    expectOut(1, 7, 0, "R5 delegated low bit blocked, higher wins");
  endtask

  task automatic testNone();
    apply('0, 32'hFFFF_FFFF, '0, U, 1, 1, 1, 0);
    expectOut(0, 0, 0, "R6 nothing pending");
  endtask

  task automatic testGuestMasked();
    apply(32'h0000_0444, 32'hFFFF_FFFF, '0, U, 1, 1, 1, 0);
    expectOut(0, 0, 0, "R7 guest bits alone outside guest mode");
    apply(32'h0000_1444, 32'hFFFF_FFFF, '0, U, 1, 1, 1, 0);
    expectOut(1, 12, 0, "R7 guest bits skipped");
  endtask

  task automatic testHostFirst();
    apply(32'h0000_04C4, 32'hFFFF_FFFF, 32'h80, S, 0, 0, 1, 1);
    expectOut(1, 7, 1, "R8 host bit beats guest bits, delegation ignored");
    apply(32'h0000_0484, 32'hFFFF_FFFF, '0, U, 0, 0, 0, 1);
    expectOut(1, 7, 1, "R8 user mode opens host path");
  endtask

  task automatic testGuestShift();
    apply(32'h0000_0484, 32'hFFFF_FFFF, '0, S, 0, 0, 0, 1);
    expectOut(1, 1, 0, "R9 host path closed, bit 2 moves to 1");
    apply(32'h0000_0400, 32'hFFFF_FFFF, 32'h200, S, 0, 1, 0, 1);
    expectOut(1, 9, 0, "R9 bit 10 moves to 9, delegated, enabled");
    apply(32'h0000_0400, 32'hFFFF_FFFF, 32'h200, S, 1, 0, 0, 1);
    expectOut(0, 0, 0, "R9 moved bit delegated with supervisor enable off");
  endtask

  task automatic testLatency();
    apply(32'h10, 32'h10, '0, M, 1, 0, 0, 0);
    expectOut(1, 4, 0, "R10 setup");
    @(negedge clk);
    pending = 32'h2; enable = 32'h2;
    #2;
    expectOut(1, 4, 0, "R10 holds until the edge");
    @(posedge clk);
    #1;
    expectOut(1, 1, 0, "R10 updates at the edge");
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (2) @(posedge clk);
    testReset();
    testCandidates();
    testPriority();
    testMachineGate();
    testDelegation();
    testNone();
    testGuestMasked();
    testHostFirst();
    testGuestShift();
    testLatency();
    testReset();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule